// File: doc/BRIEF.md
# Three-Level DMA Address Translator

This block turns a DMA address issued by a device function into a host address. It walks a table tree held in memory: the root table is indexed by one field of the address, the entry found there points at a middle table indexed by a second field, and that entry points at a leaf table indexed by a third field. The leaf entry supplies the host page and its access flags. Memory is reached through a simple port that issues one 64-bit read request at a time and waits for its response.

Each request carries the address and a snapshot of the function's state: whether it is configured, whether it is enabled, whether translation is switched on, the root table origin, and the inclusive address window the function may use. All of these are captured when the request is accepted. Before any memory is read, the block decides whether the function may translate at all, whether the address is the fixed interrupt-message address (passed through to the interrupt space without a walk), and whether the origin and window are valid. Any failure ends the request with permission none and an error-event pulse. That pulse comes with pulses that ask the owner to set the function's error state and its store-blocked state.

Only one request is handled at a time. A single-cycle done pulse marks the cycle in which all result and event outputs are valid.

Top module: `dma_xlate_walker`

## Requirements
- R1: If the captured configured, enabled or translation-enabled input is low, the request completes with res_perm_rw=0, res_irq_space=0, res_addr=0, res_mask all ones, no memory read and no event. This check takes priority over every other check.
- R2: An address equal to the parameter MSI_ADDR (default 0x0C00_0000) is not walked. It completes with res_addr equal to the address, res_mask=0xFFF, res_perm_rw=1, res_irq_space=1, no memory read and no event. This holds even when the table origin is zero or the address is outside the window.
- R3: A table origin that is zero once its low 3 bits are cleared gives event code 0x10 with qualifier 0 and no memory read. This check comes before the window check.
- R4: An address below fn_range_base or above fn_range_limit gives event code 0x11 with qualifier 0 and no memory read. The two bounds themselves are inside the window.
- R5: The walk issues up to three reads, one at a time, in this order. Root: origin (low 3 bits cleared) + 8*addr[52:42]. Middle: root entry with bits [11:0] cleared, + 8*addr[41:31]. Leaf: middle entry with bits [11:0] cleared, + 8*addr[19:12].
- R6: A root entry whose bits [3:2] are not 2'b11, a middle entry whose bits [3:2] are not 2'b10, or an entry of the right type whose pointer (bits [11:0] cleared) is zero, ends the walk at once. No further read is issued, and the result is event code 0x12 with qualifier 1.
- R7: A leaf entry equal to zero gives event code 0x12 with qualifier 1. Qualifier 1 appears only with code 0x12.
- R8: A nonzero leaf entry gives res_addr = entry with bits [11:0] cleared and res_mask=0xFFF. res_perm_rw is 0 when entry bit 10 is set and 1 otherwise. No event is raised.
- R9: busy rises in the cycle after a request is accepted (req_valid while not busy) and stays high through the single done cycle. A request raised while busy is ignored.
- R10: Every event has evt_valid, err_state_set and stg_block_set high together in the done cycle, with evt_addr equal to the request address, res_perm_rw=0 and res_mask all ones. None of these pulse at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translate request, accepted when not busy |
| req_addr | input | 64 | DMA address to translate |
| fn_configured | input | 1 | Function is configured |
| fn_enabled | input | 1 | Function is enabled |
| fn_xlate_en | input | 1 | Translation is switched on for the function |
| fn_table_origin | input | 64 | Root table origin; low 3 bits are flags |
| fn_range_base | input | 64 | Lowest address in the window |
| fn_range_limit | input | 64 | Highest address in the window |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | 64 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry read |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| res_addr | output | 64 | Translated or passed-through address |
| res_mask | output | 64 | Page offset mask |
| res_perm_rw | output | 1 | 1 = read-write, 0 = no access |
| res_irq_space | output | 1 | Result targets the interrupt space |
| evt_valid | output | 1 | Error event request |
| evt_code | output | 8 | Event code |
| evt_qual | output | 1 | Event qualifier bit |
| evt_addr | output | 64 | Faulting address |
| err_state_set | output | 1 | Set the function's error state |
| stg_block_set | output | 1 | Set the function's store-blocked state |

## Verification
A memory model answers the reads from a sparse table tree. The translations use a valid leaf, a leaf marked invalid, an empty leaf, a root entry of the wrong type, a middle entry of the wrong type, and a root entry with a zero pointer. Comparing the number of reads made with the result tells apart the three levels at which a walk can stop. The gating inputs are cleared one at a time. The interrupt address is sent both with good state and with states that would otherwise fail, which shows the order in which the checks are applied. The window is tested exactly at its bounds and one address past each bound. Response latency is varied, and the exact read addresses for one walk are logged.

// File: rtl/dxw_pkg.sv
package dxw_pkg;
  localparam int AW       = 64;
  localparam int RT_LSB   = 42;
  localparam int RT_W     = 11;
  localparam int ST_LSB   = 31;
  localparam int ST_W     = 11;
  localparam int PG_LSB   = 12;
  localparam int PG_W     = 8;
  localparam int ENT_SH   = 3;
  localparam int PAGE_SH  = 12;
  localparam int TT_LSB   = 2;
  localparam int TT_W     = 2;
  localparam int INV_BIT  = 10;
  localparam int N_LEVELS = 3;
  localparam int EVT_W    = 8;

  localparam logic [TT_W-1:0]  TT_ROOT = 2'b11;
  localparam logic [TT_W-1:0]  TT_MID  = 2'b10;
  localparam logic [EVT_W-1:0] EVT_NO_SPACE = 8'h10;
  localparam logic [EVT_W-1:0] EVT_RANGE    = 8'h11;
  localparam logic [EVT_W-1:0] EVT_WALK     = 8'h12;

  localparam logic [AW-1:0] PAGE_MASK = AW'((64'd1 << PAGE_SH) - 64'd1);
  localparam logic [AW-1:0] FLAG_MASK = AW'((64'd1 << ENT_SH) - 64'd1);

  typedef enum logic [2:0] {V_OFF, V_MSI, V_NOSPACE, V_RANGE, V_WALK} verdict_e;
  typedef enum logic [1:0] {LV_ROOT = 2'd0, LV_MID = 2'd1, LV_LEAF = 2'd2} level_e;

  function automatic logic [AW-1:0] level_index(input logic [AW-1:0] a, input level_e lv);
    case (lv)
      LV_ROOT: return AW'(a[RT_LSB +: RT_W]);
      LV_MID:  return AW'(a[ST_LSB +: ST_W]);
      default: return AW'(a[PG_LSB +: PG_W]);
    endcase
  endfunction

  function automatic logic [AW-1:0] entry_slot(input logic [AW-1:0] base, input logic [AW-1:0] idx);
    return base + (idx << ENT_SH);
  endfunction

  function automatic logic [AW-1:0] clean_origin(input logic [AW-1:0] o);
    return o & ~FLAG_MASK;
  endfunction

  function automatic logic [AW-1:0] next_table(input logic [AW-1:0] ent, input logic [TT_W-1:0] want);
    return (ent[TT_LSB +: TT_W] == want) ? (ent & ~PAGE_MASK) : '0;
  endfunction

  function automatic logic [AW-1:0] page_frame(input logic [AW-1:0] ent);
    return ent & ~PAGE_MASK;
  endfunction
endpackage

// File: rtl/dxw_gate.sv
module dxw_gate
  import dxw_pkg::*;
#(
  parameter logic [AW-1:0] MSI_ADDR = 64'h0000_0000_0C00_0000
) (
  input  logic           conf,
  input  logic           en,
  input  logic           xen,
  input  logic [AW-1:0]  addr,
  input  logic [AW-1:0]  origin,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  limit,
  output verdict_e       verdict,
  output logic [AW-1:0]  root
);
  logic fn_ok_w, msi_hit_w, no_space_w, out_win_w;

  assign root       = clean_origin(origin);
  assign fn_ok_w    = conf && en && xen;
  assign msi_hit_w  = (addr == MSI_ADDR);
  assign no_space_w = (root == '0);
  assign out_win_w  = (addr < base) || (addr > limit);

  always_comb begin
    if (!fn_ok_w)        verdict = V_OFF;
    else if (msi_hit_w)  verdict = V_MSI;
    else if (no_space_w) verdict = V_NOSPACE;
    else if (out_win_w)  verdict = V_RANGE;
    else                 verdict = V_WALK;
  end
endmodule

// File: rtl/dxw_slot.sv
module dxw_slot
  import dxw_pkg::*;
(
  input  logic [AW-1:0] root,
  input  logic [AW-1:0] walk_base,
  input  logic [AW-1:0] addr,
  input  level_e        level,
  output logic [AW-1:0] slot_addr
);
  logic [AW-1:0] cand [N_LEVELS];

  for (genvar g = 0; g < N_LEVELS; g++) begin : g_lv
    if (g == 0) begin : g_root
      assign cand[g] = entry_slot(root, level_index(addr, level_e'(2'(g))));
    end else begin : g_walk
      assign cand[g] = entry_slot(walk_base, level_index(addr, level_e'(2'(g))));
    end
  end

  always_comb begin
    case (level)
      LV_ROOT: slot_addr = cand[0];
      LV_MID:  slot_addr = cand[1];
      default: slot_addr = cand[2];
    endcase
  end
endmodule

// File: rtl/dxw_walk_ctl.sv
module dxw_walk_ctl
  import dxw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  verdict_e         verdict,
  input  logic [AW-1:0]    addr,
  input  logic             mem_rsp_valid,
  input  logic [AW-1:0]    mem_rsp_data,
  output logic             busy,
  output logic             done,
  output logic             mem_req,
  output logic             deciding,
  output level_e           level,
  output logic [AW-1:0]    walk_base,
  output logic [AW-1:0]    res_addr,
  output logic [AW-1:0]    res_mask,
  output logic             res_perm_rw,
  output logic             res_irq_space,
  output logic             evt_valid,
  output logic [EVT_W-1:0] evt_code,
  output logic             evt_qual
);
  typedef enum logic [2:0] {S_IDLE, S_DECIDE, S_ISSUE, S_WAIT, S_FINISH} st_e;

  st_e              state;
  logic             evt_pend;
  logic [EVT_W-1:0] code_q;
  logic             qual_q;
  logic [AW-1:0]    nb_w;
  logic             step_fail_w;

  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FINISH);
  assign mem_req  = (state == S_ISSUE);
  assign deciding = (state == S_DECIDE);

  assign nb_w        = next_table(mem_rsp_data, (level == LV_ROOT) ? TT_ROOT : TT_MID);
  assign step_fail_w = (level == LV_LEAF) ? (mem_rsp_data == '0) : (nb_w == '0);

  assign evt_valid = done && evt_pend;
  assign evt_code  = evt_valid ? code_q : '0;
  assign evt_qual  = evt_valid && qual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      level         <= LV_ROOT;
      walk_base     <= '0;
      res_addr      <= '0;
      res_mask      <= '0;
      res_perm_rw   <= 1'b0;
      res_irq_space <= 1'b0;
      evt_pend      <= 1'b0;
      code_q        <= '0;
      qual_q        <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state         <= S_DECIDE;
            level         <= LV_ROOT;
            walk_base     <= '0;
            res_addr      <= '0;
            res_mask      <= '1;
            res_perm_rw   <= 1'b0;
            res_irq_space <= 1'b0;
            evt_pend      <= 1'b0;
            code_q        <= '0;
            qual_q        <= 1'b0;
          end
        end
        S_DECIDE: begin
          case (verdict)
            V_OFF: state <= S_FINISH;
            V_MSI: begin
              res_addr      <= addr;
              res_mask      <= PAGE_MASK;
              res_perm_rw   <= 1'b1;
              res_irq_space <= 1'b1;
              state         <= S_FINISH;
            end
            V_NOSPACE: begin
              evt_pend <= 1'b1;
              code_q   <= EVT_NO_SPACE;
              state    <= S_FINISH;
            end
            V_RANGE: begin
              evt_pend <= 1'b1;
              code_q   <= EVT_RANGE;
              state    <= S_FINISH;
            end
            default: state <= S_ISSUE;
          endcase
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: begin
          if (mem_rsp_valid) begin
            if (step_fail_w) begin
              evt_pend <= 1'b1;
              code_q   <= EVT_WALK;
              qual_q   <= 1'b1;
              state    <= S_FINISH;
            end else if (level == LV_LEAF) begin
              res_addr    <= page_frame(mem_rsp_data);
              res_mask    <= PAGE_MASK;
              res_perm_rw <= !mem_rsp_data[INV_BIT];
              state       <= S_FINISH;
            end else begin
              walk_base <= nb_w;
              level     <= (level == LV_ROOT) ? LV_MID : LV_LEAF;
              state     <= S_ISSUE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
  import dxw_pkg::*;
#(
  parameter logic [AW-1:0] MSI_ADDR = 64'h0000_0000_0C00_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic             fn_configured,
  input  logic             fn_enabled,
  input  logic             fn_xlate_en,
  input  logic [AW-1:0]    fn_table_origin,
  input  logic [AW-1:0]    fn_range_base,
  input  logic [AW-1:0]    fn_range_limit,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rsp_valid,
  input  logic [AW-1:0]    mem_rsp_data,
  output logic             busy,
  output logic             done,
  output logic [AW-1:0]    res_addr,
  output logic [AW-1:0]    res_mask,
  output logic             res_perm_rw,
  output logic             res_irq_space,
  output logic             evt_valid,
  output logic [EVT_W-1:0] evt_code,
  output logic             evt_qual,
  output logic [AW-1:0]    evt_addr,
  output logic             err_state_set,
  output logic             stg_block_set
);
  logic          start_w;
  logic          cap_conf, cap_en, cap_xen;
  logic [AW-1:0] cap_addr, cap_origin, cap_base, cap_limit;
  verdict_e      verdict_w;
  logic [AW-1:0] root_w, walk_base_w;
  level_e        level_w;
  logic          deciding_w;
  logic          decide_off_w;

  assign start_w = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_conf   <= 1'b0;
      cap_en     <= 1'b0;
      cap_xen    <= 1'b0;
      cap_addr   <= '0;
      cap_origin <= '0;
      cap_base   <= '0;
      cap_limit  <= '0;
    end else if (start_w) begin
      cap_conf   <= fn_configured;
      cap_en     <= fn_enabled;
      cap_xen    <= fn_xlate_en;
      cap_addr   <= req_addr;
      cap_origin <= fn_table_origin;
      cap_base   <= fn_range_base;
      cap_limit  <= fn_range_limit;
    end
  end

  dxw_gate #(.MSI_ADDR(MSI_ADDR)) u_gate (
    .conf(cap_conf), .en(cap_en), .xen(cap_xen),
    .addr(cap_addr), .origin(cap_origin), .base(cap_base), .limit(cap_limit),
    .verdict(verdict_w), .root(root_w)
  );

  dxw_slot u_slot (
    .root(root_w), .walk_base(walk_base_w), .addr(cap_addr),
    .level(level_w), .slot_addr(mem_addr)
  );

  dxw_walk_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start_w), .verdict(verdict_w), .addr(cap_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .busy(busy), .done(done), .mem_req(mem_req), .deciding(deciding_w),
    .level(level_w), .walk_base(walk_base_w),
    .res_addr(res_addr), .res_mask(res_mask), .res_perm_rw(res_perm_rw),
    .res_irq_space(res_irq_space), .evt_valid(evt_valid), .evt_code(evt_code),
    .evt_qual(evt_qual)
  );

  assign decide_off_w  = deciding_w && (verdict_w == V_OFF);
  assign evt_addr      = evt_valid ? cap_addr : '0;
  assign err_state_set = evt_valid;
  assign stg_block_set = evt_valid;
endmodule

// File: rtl/dxw_checker.sv
module dxw_checker
  import dxw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic             mem_req,
  input logic [AW-1:0]    mem_addr,
  input logic             evt_valid,
  input logic [EVT_W-1:0] evt_code,
  input logic             evt_qual,
  input logic [AW-1:0]    res_mask,
  input logic             res_perm_rw,
  input logic             res_irq_space,
  input logic             decide_off
);
  AST_OFF_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    decide_off |=> done && !mem_req && !res_perm_rw && !evt_valid); // R1
  AST_MSI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_irq_space |-> res_perm_rw && (res_mask == PAGE_MASK) && !evt_valid); // R2
  AST_SLOT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[ENT_SH-1:0] == '0)); // R5
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req && busy); // R5
  AST_QUAL_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_qual == (evt_code == EVT_WALK))); // R7
  AST_EVT_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> done && !res_perm_rw && !res_irq_space && (res_mask == '1)); // R10
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy && !done); // R9
  AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !evt_valid); // R9
endmodule

bind dma_xlate_walker dxw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_addr(mem_addr), .evt_valid(evt_valid),
  .evt_code(evt_code), .evt_qual(evt_qual), .res_mask(res_mask),
  .res_perm_rw(res_perm_rw), .res_irq_space(res_irq_space),
  .decide_off(decide_off_w)
);

// File: tb/test_dma_xlate_walker.sv
`timescale 1ns/1ps
module test_dma_xlate_walker;
  localparam logic [63:0] MSI = 64'h0000_0000_0C00_0000;
  localparam logic [63:0] T0  = 64'h0000_0000_0001_0000;
  localparam logic [63:0] A1  = 64'h0000_0401_0000_3ABC;
  localparam logic [63:0] A2  = 64'h0000_0401_0000_4000;
  localparam logic [63:0] A3  = 64'h0000_0401_0000_5000;
  localparam logic [63:0] A4  = 64'h0000_0800_0000_0000;
  localparam logic [63:0] A5  = 64'h0000_0401_8000_0000;
  localparam logic [63:0] A6  = 64'h0000_0C00_0000_0000;
  localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic [63:0] addr;
    logic [2:0]  gate;
    logic [63:0] origin;
    logic [63:0] base;
    logic [63:0] limit;
    logic [63:0] exp_addr;
    logic        exp_rw;
    logic        exp_irq;
    logic        exp_pg;
    logic [7:0]  exp_code;
    logic [1:0]  exp_reads;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{A1, 3'b111, T0, 64'd0, ALL, 64'h5555_6000, 1'b1, 1'b0, 1'b1, 8'h00, 2'd3},  // R8 R5
    '{A2, 3'b111, T0, 64'd0, ALL, 64'h7777_7000, 1'b0, 1'b0, 1'b1, 8'h00, 2'd3},  // R8 invalid
    '{A3, 3'b111, T0, 64'd0, ALL, 64'd0, 1'b0, 1'b0, 1'b0, 8'h12, 2'd3},          // R7
    '{A4, 3'b111, T0, 64'd0, ALL, 64'd0, 1'b0, 1'b0, 1'b0, 8'h12, 2'd1},          // R6 root type
    '{A5, 3'b111, T0, 64'd0, ALL, 64'd0, 1'b0, 1'b0, 1'b0, 8'h12, 2'd2},          // R6 mid type
    '{A6, 3'b111, T0, 64'd0, ALL, 64'd0, 1'b0, 1'b0, 1'b0, 8'h12, 2'd1},          // R6 zero ptr
    '{A1, 3'b011, T0, 64'd0, ALL, 64'd0, 1'b0, 1'b0, 1'b0, 8'h00, 2'd0},          // R1
    '{A1, 3'b101, T0, 64'd0, ALL, 64'd0, 1'b0, 1'b0, 1'b0, 8'h00, 2'd0},          // R1
    '{A1, 3'b110, T0, 64'd0, ALL, 64'd0, 1'b0, 1'b0, 1'b0, 8'h00, 2'd0},          // R1
    '{MSI, 3'b111, T0, 64'd0, ALL, MSI, 1'b1, 1'b1, 1'b1, 8'h00, 2'd0},           // R2
    '{MSI, 3'b110, T0, 64'd0, ALL, 64'd0, 1'b0, 1'b0, 1'b0, 8'h00, 2'd0},         // R1 before R2
    '{MSI, 3'b111, 64'd0, A1, A1, MSI, 1'b1, 1'b1, 1'b1, 8'h00, 2'd0},            // R2 bypass
    '{A1, 3'b111, 64'h7, 64'd0, ALL, 64'd0, 1'b0, 1'b0, 1'b0, 8'h10, 2'd0},       // R3
    '{A1, 3'b111, T0, A1 + 64'd1, ALL, 64'd0, 1'b0, 1'b0, 1'b0, 8'h11, 2'd0},     // R4 below
    '{A1, 3'b111, T0, 64'd0, A1 - 64'd1, 64'd0, 1'b0, 1'b0, 1'b0, 8'h11, 2'd0},   // R4 above
    '{A1, 3'b111, T0, A1, A1, 64'h5555_6000, 1'b1, 1'b0, 1'b1, 8'h00, 2'd3},      // R4 bounds
    '{A1, 3'b111, 64'd0, A1 + 64'd1, ALL, 64'd0, 1'b0, 1'b0, 1'b0, 8'h10, 2'd0}   // R3 before R4
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_addr;
  logic        fn_configured, fn_enabled, fn_xlate_en;
  logic [63:0] fn_table_origin, fn_range_base, fn_range_limit;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        busy, done, res_perm_rw, res_irq_space, evt_valid, evt_qual;
  logic        err_state_set, stg_block_set;
  logic [63:0] res_addr, res_mask, evt_addr;
  logic [7:0]  evt_code;

  logic [63:0] mem_tbl [logic [63:0]];
  logic [63:0] rd_log [4];
  int          rd_cnt = 0;
  int          rsp_lat = 1;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_xlate_walker #(.MSI_ADDR(MSI)) i_dma_xlate_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .fn_configured(fn_configured), .fn_enabled(fn_enabled), .fn_xlate_en(fn_xlate_en),
    .fn_table_origin(fn_table_origin), .fn_range_base(fn_range_base),
    .fn_range_limit(fn_range_limit), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .busy(busy),
    .done(done), .res_addr(res_addr), .res_mask(res_mask), .res_perm_rw(res_perm_rw),
    .res_irq_space(res_irq_space), .evt_valid(evt_valid), .evt_code(evt_code),
    .evt_qual(evt_qual), .evt_addr(evt_addr), .err_state_set(err_state_set),
    .stg_block_set(stg_block_set)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: one response per request after rsp_lat cycles
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req) begin
        logic [63:0] a;
        a = mem_addr;
        if (rd_cnt < 4) rd_log[rd_cnt] = a;
        rd_cnt++;
        repeat (rsp_lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_tbl.exists(a) ? mem_tbl[a] : 64'd0;
      end
    end
  end

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input vec_t v, input int id);
    bit ok;
    logic [63:0] exp_mask;
    @(negedge clk);
    req_addr        = v.addr;
    {fn_configured, fn_enabled, fn_xlate_en} = v.gate;
    fn_table_origin = v.origin;
    fn_range_base   = v.base;
    fn_range_limit  = v.limit;
    rd_cnt          = 0;
    req_valid       = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !done, "R9", $sformatf("vec %0d busy after accept", id), {62'd0, busy, done}, 64'd2);
    wait_done(ok);
    chk(ok, "R9", $sformatf("vec %0d done seen", id), {63'd0, ok}, 64'd1);
    exp_mask = v.exp_pg ? 64'hFFF : ALL;
    chk(res_addr == v.exp_addr, "R8", $sformatf("vec %0d res_addr", id), res_addr, v.exp_addr);
    chk(res_mask == exp_mask, "R8", $sformatf("vec %0d res_mask", id), res_mask, exp_mask);
    chk(res_perm_rw == v.exp_rw, "R1", $sformatf("vec %0d perm", id), {63'd0, res_perm_rw}, {63'd0, v.exp_rw});
    chk(res_irq_space == v.exp_irq, "R2", $sformatf("vec %0d irq space", id), {63'd0, res_irq_space}, {63'd0, v.exp_irq});
    chk(rd_cnt == int'(v.exp_reads), "R5", $sformatf("vec %0d read count", id), 64'(rd_cnt), 64'(v.exp_reads));
    chk(evt_valid == (v.exp_code != 8'h00), "R10", $sformatf("vec %0d evt_valid", id), {63'd0, evt_valid}, {63'd0, v.exp_code != 8'h00});
    chk(evt_code == v.exp_code, "R3", $sformatf("vec %0d evt_code", id), 64'(evt_code), 64'(v.exp_code));
    chk(evt_qual == (v.exp_code == 8'h12), "R7", $sformatf("vec %0d evt_qual", id), {63'd0, evt_qual}, {63'd0, v.exp_code == 8'h12});
    chk(err_state_set == evt_valid && stg_block_set == evt_valid, "R10",
        $sformatf("vec %0d state set pulses", id), {62'd0, err_state_set, stg_block_set}, {62'd0, evt_valid, evt_valid});
    if (v.exp_code != 8'h00)
      chk(evt_addr == v.addr, "R10", $sformatf("vec %0d evt_addr", id), evt_addr, v.addr);
    @(negedge clk);
    chk(!busy && !done && !evt_valid, "R9", $sformatf("vec %0d back to idle", id), {61'd0, busy, done, evt_valid}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    fn_configured = 1'b0; fn_enabled = 1'b0; fn_xlate_en = 1'b0;
    fn_table_origin = '0; fn_range_base = '0; fn_range_limit = '0;
    mem_tbl[64'h10008] = 64'h0000_0000_0002_000C;  // root slot 1 -> mid table
    mem_tbl[64'h10010] = 64'h0000_0000_0004_0008;  // root slot 2, wrong type
    mem_tbl[64'h10018] = 64'h0000_0000_0000_000C;  // root slot 3, zero pointer
    mem_tbl[64'h20010] = 64'h0000_0000_0003_0008;  // mid slot 2 -> leaf table
    mem_tbl[64'h20018] = 64'h0000_0000_0005_000C;  // mid slot 3, wrong type
    mem_tbl[64'h30018] = 64'h0000_0000_5555_6001;  // leaf 3 valid
    mem_tbl[64'h30020] = 64'h0000_0000_7777_7400;  // leaf 4 invalid flag
    repeat (3) @(negedge clk);
    // reset state
    chk(!busy && !done && !mem_req && !evt_valid && !res_perm_rw, "R9", "reset outputs",
        {59'd0, busy, done, mem_req, evt_valid, res_perm_rw}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R5: exact read addresses of one walk, slower memory
    rsp_lat = 4;
    run_vec(VECS[0], 100);
    chk(rd_log[0] == 64'h10008, "R5", "root slot addr", rd_log[0], 64'h10008);
    chk(rd_log[1] == 64'h20010, "R5", "mid slot addr", rd_log[1], 64'h20010);
    chk(rd_log[2] == 64'h30018, "R5", "leaf slot addr", rd_log[2], 64'h30018);
    rsp_lat = 2;
    run_vec(VECS[4], 101);

    // R9: request while busy is ignored
    begin
      bit ok;
      @(negedge clk);
      req_addr = A1; {fn_configured, fn_enabled, fn_xlate_en} = 3'b111;
      fn_table_origin = T0; fn_range_base = '0; fn_range_limit = ALL;
      rd_cnt = 0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      req_addr = A4; fn_table_origin = 64'd0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done(ok);
      chk(ok && res_addr == 64'h5555_6000, "R9", "busy request ignored, result", res_addr, 64'h5555_6000);
      chk(!evt_valid && rd_cnt == 3, "R9", "busy request ignored, reads", 64'(rd_cnt), 64'd3);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(!done && !busy && !mem_req, "R9", "no second completion", {61'd0, done, busy, mem_req}, 64'd0);
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule